// File: doc/BRIEF.md
# Bus Event Generator and Sequentializer

This block sits beside a bus decoder that has already split bursts into single-word accesses. Every access arrives with a kind (I/O, memory or interrupt), a direction, an address, a data word and byte enables. The block compares the access against a fixed table of event definitions and turns each match into a named event for the property monitors that follow it. An event definition selects a kind and direction, an offset window relative to a base register, and optionally a window on the masked data word.

The base register is loaded by an ordinary I/O write to a dedicated absolute address, as software does once at startup. When one access matches several definitions, the matches are held in a pending set and leave one per cycle as a one-hot vector with a valid strobe, lowest index first. While more than one match is still waiting, the input is held off with ready low.

Top module: `bus_event_seq`

## Requirements
- R1: A definition matches only accesses of its own kind (acc_kind_i: 0 = I/O, 1 = memory, 2 = interrupt) and its own direction (read only, write only, or either; acc_wr_i = 1 means write).
- R2: For I/O and memory kinds the offset is acc_addr_i minus the base register; an access whose address is below the base matches no such definition. Interrupt definitions compare the raw address (the vector number) and ignore the base.
- R3: An I/O write to absolute address CFG_ADDR (default 0xFFF0) loads the base register from the low ADDR_W data bits. It is used by accesses accepted from the next cycle on, it raises no event itself, and the base is 0 after reset.
- R4: A definition with a nonzero data mask also requires (data AND mask) to lie inside its inclusive data window, and requires acc_be_i to enable every byte lane that holds a mask bit (lane b = data bits 8b+7..8b). A zero mask ignores both data and byte enables.
- R5: All matches of one accepted access are emitted one per cycle in ascending index order, the first in the cycle after acceptance; ev_o is one-hot while ev_valid_o is high and zero otherwise. An access with no match emits nothing.
- R6: acc_ready_o is low while two or more events of the current access are still pending and high otherwise, so the next access can be accepted in the cycle that emits the last pending event.
- R7: During and right after reset acc_ready_o is high and ev_valid_o is low.
- R8: Default table (offsets relative, data windows on the masked word): E0 I/O write at 0x220, mask 0x1, window 1..1; E1 I/O write at 0x220, mask 0x1, window 0..0; E2 I/O write at 0x228, no mask; E3 I/O read in 0x200..0x2FF, no mask; E4 memory write in 0x1000..0x1FFF, no mask; E5 memory write in 0x1000..0x10FF, mask 0xFFFF, window 0x100..0x1FF; E6 interrupt of either direction at vector 3; E7 I/O write in 0x200..0x22F, mask 0xFF000000, window 0x80000000..0xFF000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access present |
| acc_ready_o | output | 1 | Access accepted when high together with valid |
| acc_kind_i | input | 2 | Access kind: 0 I/O, 1 memory, 2 interrupt |
| acc_wr_i | input | 1 | 1 for write, 0 for read |
| acc_addr_i | input | ADDR_W (16) | Absolute access address or interrupt vector |
| acc_data_i | input | DATA_W (32) | Access data word |
| acc_be_i | input | DATA_W/8 (4) | Byte enables |
| ev_valid_o | output | 1 | An event is presented this cycle |
| ev_o | output | NUM_EV (8) | One-hot event vector |

## Verification
Directed accesses land on each definition's boundaries: the same offset with data bit 0 set or clear, the top data byte above and below its threshold, a byte lane missing under a mask, a read against a write-only window, and an address just below a moved base, so that each field of the match rule is told apart from the others. Overlapping accesses that hit two definitions at once separate correct ordering and draining from single-event behaviour. Random accesses, biased toward the window edges and mixed with occasional base moves and idle gaps, are issued back to back against a cycle model of the pending set, exposing any bubble or lost event at the hand-over between one access's last event and the next acceptance.

// File: rtl/bev_pkg.sv
package bev_pkg;

  typedef enum logic [1:0] {
    KIND_IO  = 2'd0,
    KIND_MEM = 2'd1,
    KIND_IRQ = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    DIR_RD  = 2'd0,
    DIR_WR  = 2'd1,
    DIR_ANY = 2'd2
  } ev_dir_e;

  typedef struct packed {
    acc_kind_e   kind;
    ev_dir_e     dir;
    logic [31:0] off_lo;
    logic [31:0] off_hi;
    logic [31:0] mask;
    logic [31:0] dat_lo;
    logic [31:0] dat_hi;
  } ev_def_t;

  // Event table; indices beyond the table get an empty window.
  function automatic ev_def_t ev_def(int unsigned idx);
    ev_def_t d;
    d = '{kind: KIND_IRQ, dir: DIR_ANY, off_lo: 32'd1, off_hi: 32'd0,
          mask: 32'd0, dat_lo: 32'd0, dat_hi: 32'd0};
    case (idx)
      0: d = '{KIND_IO,  DIR_WR,  32'h220,  32'h220,  32'h1,        32'h1,        32'h1};
      1: d = '{KIND_IO,  DIR_WR,  32'h220,  32'h220,  32'h1,        32'h0,        32'h0};
      2: d = '{KIND_IO,  DIR_WR,  32'h228,  32'h228,  32'h0,        32'h0,        32'h0};
      3: d = '{KIND_IO,  DIR_RD,  32'h200,  32'h2FF,  32'h0,        32'h0,        32'h0};
      4: d = '{KIND_MEM, DIR_WR,  32'h1000, 32'h1FFF, 32'h0,        32'h0,        32'h0};
      5: d = '{KIND_MEM, DIR_WR,  32'h1000, 32'h10FF, 32'hFFFF,     32'h100,      32'h1FF};
      6: d = '{KIND_IRQ, DIR_ANY, 32'h3,    32'h3,    32'h0,        32'h0,        32'h0};
      7: d = '{KIND_IO,  DIR_WR,  32'h200,  32'h22F,  32'hFF000000, 32'h80000000, 32'hFF000000};
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bev_base_reg.sv
module bev_base_reg #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_fire_i,
  input  logic [1:0]        acc_kind_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  output logic              cfg_hit_o,
  output logic [ADDR_W-1:0] base_o
);
  import bev_pkg::*;

  logic [ADDR_W-1:0] base_q;

  assign cfg_hit_o = (acc_kind_i == KIND_IO) && acc_wr_i && (acc_addr_i == CFG_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       base_q <= '0;
    else if (acc_fire_i && cfg_hit_o)  base_q <= cfg_data_i;
  end

  assign base_o = base_q;

  AST_BASE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_fire_i && cfg_hit_o) |=> (base_o == $past(cfg_data_i))); // R3
  AST_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_fire_i && cfg_hit_o) |=> $stable(base_o)); // R3

endmodule

// File: rtl/bev_matcher.sv
module bev_matcher #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EV_IDX = 0,
  localparam int unsigned BE_W = DATA_W / 8
) (
  input  logic [1:0]        acc_kind_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_data_i,
  input  logic [BE_W-1:0]   acc_be_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              hit_o
);
  import bev_pkg::*;

  localparam ev_def_t DEF = ev_def(EV_IDX);
  localparam logic [ADDR_W-1:0] OFF_LO = DEF.off_lo[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] OFF_HI = DEF.off_hi[ADDR_W-1:0];
  localparam logic [DATA_W-1:0] MASK   = DEF.mask[DATA_W-1:0];
  localparam logic [DATA_W-1:0] DAT_LO = DEF.dat_lo[DATA_W-1:0];
  localparam logic [DATA_W-1:0] DAT_HI = DEF.dat_hi[DATA_W-1:0];
  localparam logic [1:0]        KIND   = DEF.kind;
  localparam logic IS_IRQ   = (DEF.kind == KIND_IRQ);
  localparam logic DIR_ANYL = (DEF.dir == DIR_ANY);
  localparam logic DIR_WRL  = (DEF.dir == DIR_WR);
  localparam logic CHK_DATA = (MASK != '0);

  function automatic logic [BE_W-1:0] lanes_of(logic [DATA_W-1:0] m);
    logic [BE_W-1:0] r;
    for (int b = 0; b < BE_W; b++) r[b] = |m[b*8 +: 8];
    return r;
  endfunction

  localparam logic [BE_W-1:0] BE_NEED = lanes_of(MASK);

  logic [ADDR_W:0]   rel;
  logic [ADDR_W-1:0] off;
  logic              below;
  logic [ADDR_W:0]   d_off_lo, d_off_hi;
  logic [DATA_W-1:0] masked;
  logic [DATA_W:0]   d_dat_lo, d_dat_hi;
  logic kind_ok, dir_ok, addr_ok, data_ok;

  always_comb begin
    rel   = {1'b0, acc_addr_i} - {1'b0, base_i};
    off   = IS_IRQ ? acc_addr_i : rel[ADDR_W-1:0];
    below = IS_IRQ ? 1'b0 : rel[ADDR_W];
    // borrow-based compares keep constant bounds free of width corner cases
    d_off_lo = {1'b0, off} - {1'b0, OFF_LO};
    d_off_hi = {1'b0, OFF_HI} - {1'b0, off};
    addr_ok  = !below && !d_off_lo[ADDR_W] && !d_off_hi[ADDR_W];

    masked   = acc_data_i & MASK;
    d_dat_lo = {1'b0, masked} - {1'b0, DAT_LO};
    d_dat_hi = {1'b0, DAT_HI} - {1'b0, masked};
    data_ok  = !CHK_DATA ||
               (!d_dat_lo[DATA_W] && !d_dat_hi[DATA_W] && ((acc_be_i & BE_NEED) == BE_NEED));

    kind_ok = (acc_kind_i == KIND);
    dir_ok  = DIR_ANYL || (acc_wr_i == DIR_WRL);
    hit_o   = kind_ok && dir_ok && addr_ok && data_ok;
  end

endmodule

// File: rtl/bev_serializer.sv
module bev_serializer #(
  parameter int unsigned NUM_EV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [NUM_EV-1:0] hit_i,
  input  logic              cfg_hit_i,
  output logic              acc_ready_o,
  output logic              ev_valid_o,
  output logic [NUM_EV-1:0] ev_o
);
  localparam logic [NUM_EV-1:0] ONE = {{(NUM_EV-1){1'b0}}, 1'b1};

  logic [NUM_EV-1:0] pend_q, pend_d, head, rest;
  logic              fire;

  always_comb begin
    head        = pend_q & (~pend_q + ONE);   // lowest index first
    rest        = pend_q & ~head;
    acc_ready_o = (rest == '0);
    fire        = acc_valid_i && acc_ready_o;
    if (fire) pend_d = cfg_hit_i ? '0 : hit_i;
    else      pend_d = rest;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign ev_valid_o = (pend_q != '0);
  assign ev_o       = head;

  AST_EV_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o |-> ($countones(ev_o) == 1)); // R5
  AST_EV_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_valid_o |-> (ev_o == '0)); // R5
  AST_EV_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_o && $past(ev_valid_o) && !$past(acc_valid_i && acc_ready_o))
      |-> (ev_o > $past(ev_o))); // R5
  AST_FIRE_EMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_ready_o && (hit_i != '0) && !cfg_hit_i) |=> ev_valid_o); // R5
  AST_DRAIN_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_o && !acc_ready_o) |=> ev_valid_o); // R6

endmodule

// File: rtl/bus_event_seq.sv
module bus_event_seq #(
  parameter int unsigned NUM_EV   = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 16'hFFF0,
  localparam int unsigned BE_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  output logic              acc_ready_o,
  input  logic [1:0]        acc_kind_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_data_i,
  input  logic [BE_W-1:0]   acc_be_i,
  output logic              ev_valid_o,
  output logic [NUM_EV-1:0] ev_o
);

  logic [ADDR_W-1:0] base;
  logic              cfg_hit;
  logic [NUM_EV-1:0] hit;
  logic              fire;

  assign fire = acc_valid_i && acc_ready_o;

  bev_base_reg #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_base (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_fire_i (fire),
    .acc_kind_i (acc_kind_i),
    .acc_wr_i   (acc_wr_i),
    .acc_addr_i (acc_addr_i),
    .cfg_data_i (acc_data_i[ADDR_W-1:0]),
    .cfg_hit_o  (cfg_hit),
    .base_o     (base)
  );

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    bev_matcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EV_IDX(i)) u_match (
      .acc_kind_i (acc_kind_i),
      .acc_wr_i   (acc_wr_i),
      .acc_addr_i (acc_addr_i),
      .acc_data_i (acc_data_i),
      .acc_be_i   (acc_be_i),
      .base_i     (base),
      .hit_o      (hit[i])
    );
  end

  bev_serializer #(.NUM_EV(NUM_EV)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .hit_i       (hit),
    .cfg_hit_i   (cfg_hit),
    .acc_ready_o (acc_ready_o),
    .ev_valid_o  (ev_valid_o),
    .ev_o        (ev_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (acc_ready_o && !ev_valid_o)); // R7

endmodule

// File: tb/tb_bus_event_seq.sv
module tb_bus_event_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic        acc_ready_o;
  logic [1:0]  acc_kind_i = '0;
  logic        acc_wr_i = 1'b0;
  logic [15:0] acc_addr_i = '0;
  logic [31:0] acc_data_i = '0;
  logic [3:0]  acc_be_i = '0;
  logic        ev_valid_o;
  logic [7:0]  ev_o;

  always #2 clk = ~clk;

  bus_event_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid_i), .acc_ready_o(acc_ready_o),
    .acc_kind_i(acc_kind_i), .acc_wr_i(acc_wr_i), .acc_addr_i(acc_addr_i),
    .acc_data_i(acc_data_i), .acc_be_i(acc_be_i),
    .ev_valid_o(ev_valid_o), .ev_o(ev_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // staged stimulus
  logic        s_valid = 0;
  logic [1:0]  s_kind = 0;
  logic        s_wr = 0;
  logic [15:0] s_addr = 0;
  logic [31:0] s_data = 0;
  logic [3:0]  s_be = 0;
  bit          hold = 0;
  bit          accepted = 0;
  logic [7:0]  exp_pend = 0;
  logic [15:0] exp_base = 0;
  logic [7:0]  seen = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Requirement table R8, interpreted by R1, R2, R4
  function automatic logic [7:0] model_match(input logic [1:0] k, input logic w,
      input logic [15:0] a, input logic [31:0] d, input logic [3:0] be, input logic [15:0] base);
    logic [7:0] r = '0;
    if (k == 2'd0 && w && a == 16'hFFF0) return '0;  // R3 base write
    for (int i = 0; i < 8; i++) begin
      int ek, dir; int unsigned lo, hi, mk, dl, dh, off; bit ok;
      case (i)
        0: begin ek=0; dir=1; lo='h220;  hi='h220;  mk='h1;        dl='h1;        dh='h1;        end
        1: begin ek=0; dir=1; lo='h220;  hi='h220;  mk='h1;        dl=0;          dh=0;          end
        2: begin ek=0; dir=1; lo='h228;  hi='h228;  mk=0;          dl=0;          dh=0;          end
        3: begin ek=0; dir=0; lo='h200;  hi='h2FF;  mk=0;          dl=0;          dh=0;          end
        4: begin ek=1; dir=1; lo='h1000; hi='h1FFF; mk=0;          dl=0;          dh=0;          end
        5: begin ek=1; dir=1; lo='h1000; hi='h10FF; mk='hFFFF;     dl='h100;      dh='h1FF;      end
        6: begin ek=2; dir=2; lo=3;      hi=3;      mk=0;          dl=0;          dh=0;          end
        default: begin ek=0; dir=1; lo='h200; hi='h22F; mk='hFF000000; dl='h80000000; dh='hFF000000; end
      endcase
      ok = (int'(k) == ek) && (dir == 2 || int'(w) == dir);
      if (k == 2'd2) off = a;
      else begin
        if (a < base) ok = 0;
        off = a - base;
      end
      if (off < lo || off > hi) ok = 0;
      if (mk != 0) begin
        if ((d & mk) < dl || (d & mk) > dh) ok = 0;
        for (int b = 0; b < 4; b++)
          if (((mk >> (8*b)) & 'hFF) != 0 && !be[b]) ok = 0;
      end
      r[i] = ok;
    end
    return r;
  endfunction

  task automatic cycle();
    logic [7:0] lo_bit, nxt;
    @(negedge clk);
    lo_bit = exp_pend & (~exp_pend + 8'd1);
    chk(acc_ready_o == ($countones(exp_pend) <= 1), rst_n ? "R6 ready" : "R7 ready",
        32'(acc_ready_o), 32'($countones(exp_pend) <= 1));
    chk(ev_valid_o == (exp_pend != 0), rst_n ? "R5 ev_valid" : "R7 ev_valid",
        32'(ev_valid_o), 32'(exp_pend != 0));
    chk(ev_o == lo_bit, "R5 ev_o", 32'(ev_o), 32'(lo_bit));
    if (ev_valid_o) seen |= ev_o;
    if (!hold) begin
      acc_valid_i = s_valid; acc_kind_i = s_kind; acc_wr_i = s_wr;
      acc_addr_i = s_addr; acc_data_i = s_data; acc_be_i = s_be;
    end
    accepted = rst_n && acc_valid_i && ($countones(exp_pend) <= 1);
    if (!rst_n) nxt = '0;
    else if (accepted) begin
      nxt = model_match(acc_kind_i, acc_wr_i, acc_addr_i, acc_data_i, acc_be_i, exp_base);
      if (acc_kind_i == 2'd0 && acc_wr_i && acc_addr_i == 16'hFFF0) exp_base = acc_data_i[15:0];
    end else nxt = exp_pend & ~lo_bit;
    hold = rst_n && acc_valid_i && !accepted;
    exp_pend = nxt;
  endtask

  task automatic send(input logic [1:0] k, input logic w, input logic [15:0] a,
      input logic [31:0] d, input logic [3:0] be, input logic [7:0] exp, input string tag);
    s_valid = 1; s_kind = k; s_wr = w; s_addr = a; s_data = d; s_be = be;
    cycle();
    while (!accepted) cycle();
    s_valid = 0;
    seen = 0;
    repeat (10) cycle();
    chk(seen == exp, tag, 32'(seen), 32'(exp));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) cycle();                       // R7 checked inside cycle during reset
    rst_n = 1'b1;
    cycle();
    chk(acc_ready_o && !ev_valid_o, "R7 after reset", 32'({acc_ready_o, ev_valid_o}), 32'h2);

    send(0, 1, 16'h0220, 32'h1,        4'hF, 8'h01, "R8 E0 counter enable, base 0");
    send(0, 1, 16'h0220, 32'h80000001, 4'hF, 8'h81, "R5 E0+E7 in order");
    send(0, 1, 16'h0220, 32'h80000001, 4'h7, 8'h01, "R4 missing lane 3 drops E7");
    send(0, 0, 16'h0220, 32'h1,        4'hF, 8'h08, "R1 read hits E3 only");
    send(1, 1, 16'h1010, 32'h150,      4'h3, 8'h30, "R4 E4+E5 data in window");
    send(1, 1, 16'h1010, 32'h250,      4'hF, 8'h10, "R4 data above window");
    send(1, 0, 16'h1010, 32'h150,      4'hF, 8'h00, "R1 memory read no match");
    send(2, 0, 16'h0003, 32'h0,        4'h0, 8'h40, "R2 interrupt vector");
    send(0, 1, 16'hFFF0, 32'h4000,     4'hF, 8'h00, "R3 base write raises nothing");
    send(0, 1, 16'h4220, 32'h1,        4'hF, 8'h01, "R3 offset from new base");
    send(0, 1, 16'h0220, 32'h1,        4'hF, 8'h00, "R2 below base");
    send(2, 1, 16'h0003, 32'h0,        4'h0, 8'h40, "R2 interrupt ignores base");
    send(0, 1, 16'h4228, 32'h0,        4'h0, 8'h04, "R4 zero mask ignores lanes");
    send(0, 1, 16'h4220, 32'h0,        4'h1, 8'h02, "R8 E1 counter disable");
    send(0, 1, 16'h4200, 32'h80000000, 4'h8, 8'h80, "R8 E7 low edge");

    // back-to-back R6: base write immediately followed by accesses
    s_valid = 1; s_kind = 0; s_wr = 1; s_addr = 16'hFFF0; s_data = 32'h0; s_be = 4'hF;
    cycle();
    for (int n = 0; n < 6000; n++) begin
      if (!hold) begin
        int unsigned pick;
        s_valid = ($urandom % 10) < 8;
        s_kind = 2'($urandom % 3);
        s_wr = 1'($urandom);
        pick = $urandom % 12;
        case (pick)
          0: s_addr = 16'h0220; 1: s_addr = 16'h0228; 2: s_addr = 16'h0200;
          3: s_addr = 16'h022F; 4: s_addr = 16'h0230; 5: s_addr = 16'h1000;
          6: s_addr = 16'h10FF; 7: s_addr = 16'h1100; 8: s_addr = 16'h1FFF;
          9: s_addr = 16'h0003; 10: s_addr = 16'hFFF0;
          default: s_addr = 16'($urandom);
        endcase
        if (s_kind != 2 && s_addr != 16'hFFF0) s_addr = s_addr + exp_base;
        case ($urandom % 8)
          0: s_data = 32'h1; 1: s_data = 32'h0; 2: s_data = 32'h80000001;
          3: s_data = 32'h150; 4: s_data = 32'h100; 5: s_data = 32'h1FF;
          6: s_data = 32'h7F000000;
          default: s_data = $urandom;
        endcase
        if (s_addr == 16'hFFF0 && s_kind == 0 && s_wr) s_data = ($urandom % 2) ? 32'h0 : 32'h3000;
        s_be = ($urandom % 3 == 0) ? 4'($urandom) : 4'hF;
      end
      cycle();
    end
    s_valid = 0;
    repeat (12) cycle();

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule